// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block fades a signed digital audio stream down to a deep attenuation, or back up to unity, along a logarithmic path, so that muting and unmuting produce no audible click. Attenuation is held as a count of 1 dB steps. Each count maps to a linear Q1.15 coefficient, so a constant step rate in dB gives an exponential-looking fade in the linear domain. The count moves one step per tick of a rate divider. Two divider periods are available: a fast one and a slow one.

A mute can be requested by a control bit or by pulling an asynchronous, active-low pin. The pin passes through a two-flop synchroniser and is then ORed with the control bit. The status output follows the merged request straight away, so it does not wait for the fade to finish. A separate hard-cut bit zeroes the coefficient and the output at the next clock edge. The logarithmic counter keeps moving underneath, and when the cut is lifted the gain resumes from wherever the counter has reached.

Top module: `smute_ramp`

## Requirements
- R1: While reset is held, gain_o reads 32768 (unity in Q1.15), sample_o reads 0 and mute_stat_o reads 0. The attenuation count and the divider count both start at 0.
- R2: The mute request is mute_req_i OR the inverse of ext_mute_ni. The pin passes through two synchroniser flops, so a low level on ext_mute_ni shows on mute_stat_o after the third rising edge.
- R3: mute_stat_o takes the value of the request one edge after mute_req_i changes. This happens while the gain is still at its old value, not at the end of the fade.
- R4: While the attenuation count differs from its target, it moves by exactly one step every FAST_DIV cycles when slow_sel_i = 0, or every SLOW_DIV cycles when slow_sel_i = 1. The first step lands DIV edges after the edge on which mute_stat_o changed.
- R5: For an attenuation count a, gain_o = round(32768 * 10^(-(a mod 6)/20)) shifted right by floor(a/6) bits. It is registered together with the count.
- R6: With mute requested, the count rises to ATT_MAX (default 60, gain 32) and stays there.
- R7: With the request removed, the count falls at the same per-slope rate back to 0, where gain_o is 32768.
- R8: When hard_cut_i = 1 at an edge, gain_o and sample_o are 0 after that edge. The attenuation count keeps ramping, and gain_o returns to the coefficient for the current count one edge after hard_cut_i is lowered.
- R9: sample_o after an edge equals (sample_i * gain_o before that edge) arithmetically shifted right by 15, signed, or 0 under a hard cut.
- R10: If the request reverses in the middle of a fade, the count turns around from its present value, one step at a time, with no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mute_req_i | input | 1 | Control-bit soft-mute request |
| ext_mute_ni | input | 1 | Asynchronous active-low mute pin |
| slow_sel_i | input | 1 | 0 selects the fast step period, 1 the slow one |
| hard_cut_i | input | 1 | Immediate hard mute of coefficient and output |
| sample_i | input | SW | Signed input sample |
| gain_o | output | 16 | Linear gain coefficient, Q1.15 unsigned |
| sample_o | output | SW | Scaled signed output sample |
| mute_stat_o | output | 1 | Soft-mute request status |

## Verification
The fade is exercised along several paths:
- a full fast fade down and back up, driven by the control bit;
- a slow fade started from the pin that reverses partway;
- a full slow fade, with a slope change mid-ramp;
- a hard cut applied during an upward fade.

Between them these separate the two step periods, the extra synchroniser latency of the pin, clean turnaround against a jump, and a cut that only masks the output against one that disturbs the counter. A changing sample pattern with both signs and full-scale values runs throughout. It shows whether the output uses the coefficient from before the edge and rounds negative products arithmetically.

// File: rtl/smute_pkg.sv
package smute_pkg;

    localparam int COEF_W     = 16;
    localparam int COEF_FRAC  = 15;
    localparam int STEPS_OCT  = 6;

    // Q1.15 value of 10^(-k/20) for k = 0..5
    function automatic logic [COEF_W-1:0] step_mant(input int k);
        case (k)
            0:       step_mant = 16'd32768;
            1:       step_mant = 16'd29205;
            2:       step_mant = 16'd26029;
            3:       step_mant = 16'd23198;
            4:       step_mant = 16'd20675;
            default: step_mant = 16'd18427;
        endcase
    endfunction

endpackage

// File: rtl/smute_sync.sv
module smute_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/smute_rate.sv
module smute_rate #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int DIV_MAX = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CNT_W   = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rate_t;

    rate_t            st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             tick;

    always_comb begin
        last = slow_i ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
        tick = run_i && (st_q.cnt >= last);
        st_d = st_q;
        if (!run_i || tick) st_d.cnt = '0;
        else                st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = tick;

    generate
        if (FAST_DIV >= 2 && SLOW_DIV >= 2) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R4
        end
    endgenerate
endmodule

// File: rtl/smute_lut.sv
module smute_lut #(
    parameter int ATT_W = 6
) (
    input  logic [ATT_W-1:0]              att_i,
    output logic [smute_pkg::COEF_W-1:0]  coef_o
);
    import smute_pkg::*;

    int idx;

    always_comb begin
        idx    = int'(att_i);
        coef_o = step_mant(idx % STEPS_OCT) >> (idx / STEPS_OCT);
    end
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp #(
    parameter int SW       = 16,
    parameter int ATT_MAX  = 60,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 56
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mute_req_i,
    input  logic                   ext_mute_ni,
    input  logic                   slow_sel_i,
    input  logic                   hard_cut_i,
    input  logic signed [SW-1:0]   sample_i,
    output logic [15:0]            gain_o,
    output logic signed [SW-1:0]   sample_o,
    output logic                   mute_stat_o
);
    import smute_pkg::*;

    localparam int ATT_W = $clog2(ATT_MAX + 1);
    localparam int PRD_W = SW + COEF_W + 1;

    typedef struct packed {
        logic                     stat;
        logic [ATT_W-1:0]         att;
        logic [COEF_W-1:0]        gain;
        logic signed [SW-1:0]     smp;
    } ramp_t;

    ramp_t                    st_d, st_q;
    logic                     pin_sync;
    logic                     req;
    logic [ATT_W-1:0]         att_tgt;
    logic                     run;
    logic                     tick;
    logic [COEF_W-1:0]        coef_nxt;
    logic signed [PRD_W-1:0]  prod;

    smute_sync #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_mute_ni),
        .q_o   (pin_sync)
    );

    smute_rate #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .slow_i (slow_sel_i),
        .tick_o (tick)
    );

    smute_lut #(.ATT_W(ATT_W)) u_lut (
        .att_i  (st_d.att),
        .coef_o (coef_nxt)
    );

    always_comb begin
        req     = mute_req_i | ~pin_sync;
        att_tgt = st_q.stat ? ATT_W'(ATT_MAX) : '0;
        run     = (st_q.att != att_tgt);
        prod    = sample_i * $signed({1'b0, st_q.gain});

        st_d      = st_q;
        st_d.stat = req;
        if (tick) begin
            if (st_q.stat) st_d.att = st_q.att + ATT_W'(1);
            else           st_d.att = st_q.att - ATT_W'(1);
        end
        st_d.gain = hard_cut_i ? '0 : coef_nxt;
        st_d.smp  = hard_cut_i ? '0 : SW'(prod >>> COEF_FRAC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stat: 1'b0, att: '0, gain: 16'd32768, smp: '0};
        else        st_q <= st_d;
    end

    assign gain_o      = st_q.gain;
    assign sample_o    = st_q.smp;
    assign mute_stat_o = st_q.stat;

    AST_ATT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.att <= ATT_W'(ATT_MAX)); // R6
    AST_RISE_WHEN_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.stat) |-> st_q.att >= $past(st_q.att)); // R4
    AST_FALL_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_q.stat) |-> st_q.att <= $past(st_q.att)); // R7
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.att != $past(st_q.att)) |->
            ((st_q.att - $past(st_q.att)) == ATT_W'(1) ||
             ($past(st_q.att) - st_q.att) == ATT_W'(1))); // R10
    AST_CUT_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_cut_i |=> (gain_o == '0 && sample_o == '0)); // R8
    AST_STAT_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req_i |=> mute_stat_o); // R3
endmodule

// File: tb/smute_ramp_bench.sv
module smute_ramp_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW       = 16;
    localparam int ATT_MAX  = 60;
    localparam int FAST_DIV = 4;
    localparam int SLOW_DIV = 56;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mute_req_i = 1'b0;
    logic                 ext_mute_ni = 1'b1;
    logic                 slow_sel_i = 1'b0;
    logic                 hard_cut_i = 1'b0;
    logic signed [SW-1:0] sample_i = '0;
    logic [15:0]          gain_o;
    logic signed [SW-1:0] sample_o;
    logic                 mute_stat_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int    gain;
        int    smp;
        bit    stat;
        string tag;
    } exp_t;
    exp_t sbq[$];

    // reference state, updated from the requirements at each modelled edge
    bit m_s1 = 1, m_s2 = 1, m_stat = 0;
    int m_att = 0, m_cnt = 0, m_gain = 32768, m_smp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smute_ramp #(.SW(SW), .ATT_MAX(ATT_MAX), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_smute_ramp (
        .clk(clk), .rst_n(rst_n), .mute_req_i(mute_req_i), .ext_mute_ni(ext_mute_ni),
        .slow_sel_i(slow_sel_i), .hard_cut_i(hard_cut_i), .sample_i(sample_i),
        .gain_o(gain_o), .sample_o(sample_o), .mute_stat_o(mute_stat_o)
    );

    function automatic int coef_of(int a);
        real m;
        m = 32768.0 * (10.0 ** (-real'(a % 6) / 20.0));
        return $rtoi(m + 0.5) >>> (a / 6);
    endfunction

    task automatic chk(bit ok, string tag, int got, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, expv);
        end
    endtask

    // one cycle: drive at the falling edge, predict the next rising edge
    task automatic drive(bit req, bit ext_n, bit slow, bit cut, string tag, int n);
        for (int i = 0; i < n; i++) begin
            int  smp, tgt, last, nxt_att;
            bit  run, tick, nreq;
            longint p;
            exp_t e;
            @(negedge clk);
            rst_n = 1'b1;
            cyc++;
            smp = ((cyc * 12345 + 678) % 65536) - 32768;
            if (cyc % 97 == 0) smp = -32768;
            if (cyc % 89 == 0) smp = 32767;
            mute_req_i  = req;
            ext_mute_ni = ext_n;
            slow_sel_i  = slow;
            hard_cut_i  = cut;
            sample_i    = SW'(smp);
            nreq = req | ~m_s2;
            tgt  = m_stat ? ATT_MAX : 0;
            run  = (m_att != tgt);
            last = slow ? SLOW_DIV - 1 : FAST_DIV - 1;
            tick = run && (m_cnt >= last);
            nxt_att = tick ? (m_stat ? m_att + 1 : m_att - 1) : m_att;
            m_cnt = (!run || tick) ? 0 : m_cnt + 1;
            p = longint'(smp) * longint'(m_gain);
            m_smp  = cut ? 0 : int'(p >>> 15);
            m_att  = nxt_att;
            m_gain = cut ? 0 : coef_of(m_att);
            m_s2   = m_s1;
            m_s1   = ext_n;
            m_stat = nreq;
            e.gain = m_gain; e.smp = m_smp; e.stat = m_stat; e.tag = tag;
            sbq.push_back(e);
        end
    endtask

    // monitor: compares each prediction a quarter period after its edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(int'(gain_o) == e.gain, {e.tag, " gain"}, int'(gain_o), e.gain);
                chk(int'(sample_o) == e.smp, {e.tag, " sample"}, int'(sample_o), e.smp);
                chk(mute_stat_o == e.stat, {e.tag, " status"}, int'(mute_stat_o), int'(e.stat));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog R1 got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(gain_o == 16'd32768, "R1 reset gain", int'(gain_o), 32768);
        chk(sample_o == '0, "R1 reset sample", int'(sample_o), 0);
        chk(mute_stat_o == 1'b0, "R1 reset status", int'(mute_stat_o), 0);

        // R3: status before the fade moves
        drive(1, 1, 0, 0, "R3", 2);
        chk(mute_stat_o == 1'b1, "R3 early status", int'(mute_stat_o), 1);
        chk(gain_o == 16'd32768, "R3 gain untouched", int'(gain_o), 32768);
        // R4 R5 R6 R9: fast fade to the floor
        drive(1, 1, 0, 0, "R6", 280);
        chk(gain_o == 16'd32, "R6 floor gain", int'(gain_o), 32);
        // R7: fast release
        drive(0, 1, 0, 0, "R7", 280);
        chk(gain_o == 16'd32768, "R7 unity gain", int'(gain_o), 32768);

        // R2: pin path with two synchroniser flops
        drive(0, 0, 1, 0, "R2", 3);
        chk(mute_stat_o == 1'b0, "R2 status before sync", int'(mute_stat_o), 0);
        drive(0, 0, 1, 0, "R2", 1);
        chk(mute_stat_o == 1'b1, "R2 status after sync", int'(mute_stat_o), 1);
        drive(0, 0, 1, 0, "R4", 300);
        // R10: reverse mid-fade
        drive(0, 1, 1, 0, "R10", 400);
        chk(gain_o == 16'd32768, "R10 back to unity", int'(gain_o), 32768);

        // R4: slow fade with a slope change partway
        drive(1, 1, 1, 0, "R4", 1500);
        drive(1, 1, 0, 0, "R4", 300);
        chk(gain_o == 16'd32, "R4 floor after slope change", int'(gain_o), 32);

        // R8: hard cut during the upward fade
        drive(0, 1, 1, 0, "R8", 800);
        drive(0, 1, 1, 1, "R8", 1);
        drive(0, 1, 1, 1, "R8", 1);
        chk(gain_o == '0, "R8 cut gain", int'(gain_o), 0);
        chk(sample_o == '0, "R8 cut sample", int'(sample_o), 0);
        drive(0, 1, 1, 1, "R8", 200);
        drive(0, 1, 1, 0, "R8", 3600);
        chk(gain_o == 16'd32768, "R8 unity after cut", int'(gain_o), 32768);

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule